// File: doc/BRIEF.md
# Interrupt Wakeup Dispatcher

This block collects interrupt request strobes from up to sixteen levels into a pending mask. When no wakeup-disable nesting is in force, it turns each pending level into a notify on that level's condition variable. A notify becomes a wake action when the level's wait queue holds a process. It becomes a set-waiting action when the queue is empty, so that the condition's wakeup-waiting bit is latched. The topmost level is the periodic timer channel. It is not notified. It is turned into a timeout-scan action, which is issued ahead of every other level.

Actions go out one at a time to a queue engine over a valid/ready handshake. A nesting counter suppresses dispatch while it is non-zero. Software raises and lowers it with increment and decrement strobes. A step that would take the counter negative is refused and latches an error flag. The block requests a reschedule in two cases: when a dispatch has woken a process or started from an idle machine, and when a decrement releases the counter while requests are waiting.

Top module: `irq_wake_dispatch`

## Requirements
- R1: After a synchronous reset the counter reads 0, no action is valid, the error flag is low and no reschedule is requested.
- R2: An increment strobe alone raises the counter by one and a decrement strobe alone lowers it by one. Both strobes together leave it unchanged.
- R3: An increment at the largest positive value (127), or a decrement at 0, leaves the counter unchanged and sets the error flag. The flag stays set until a clear strobe arrives in a cycle with no new error.
- R4: A dispatch starts only in a cycle where the counter is 0, no dispatch is running and the pending mask is non-zero. The whole mask is captured and cleared at that edge. Requests that arrive later wait for the next dispatch.
- R5: When the timer level (index 15) is in the captured set, the first action is a scan (kind code 2) carrying level 15. No notify is issued for that level.
- R6: The remaining captured levels are issued from the highest index to the lowest, one per accepted handshake. While valid is high and ready is low, the kind and level are held.
- R7: A notify action has kind 0 (wake) when the level's queue-empty input is low and kind 1 (set waiting) when it is high. The input is sampled one cycle before valid rises.
- R8: One cycle after the last action of a dispatch is accepted, the reschedule output pulses if at least one wake was accepted or the idle input was high when the dispatch started. Otherwise it stays low.
- R9: A decrement that takes the counter from 1 to 0 while the pending mask is non-zero pulses the reschedule output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 16 | Interrupt request strobes, one bit per level |
| dis_inc | input | 1 | Raise the wakeup-disable counter |
| dis_dec | input | 1 | Lower the wakeup-disable counter |
| err_clr | input | 1 | Clear the wakeup error flag |
| cpu_idle | input | 1 | Machine is idle (sampled when a dispatch starts) |
| q_empty | input | 16 | Per-level wait-queue empty status |
| act_ready | input | 1 | Queue engine accepts the current action |
| act_valid | output | 1 | An action is offered |
| act_kind | output | 2 | 0 wake, 1 set waiting, 2 timeout scan |
| act_level | output | 4 | Level the action refers to |
| resched_req | output | 1 | One-cycle reschedule request |
| wake_err | output | 1 | Sticky over/underflow error |
| dis_count | output | 8 | Current wakeup-disable counter |

## Verification
The hardest situation to reach is a dispatch that overlaps other activity. New requests arrive during it, the queue engine stalls it, and the counter is raised and then released while work is still waiting. The stimulus gets there by firing fresh request strobes while actions are being stalled by a ready pattern that holds off on two cycles out of three. It raises the counter before those requests can start a dispatch and then lowers it to 0, so the decrement-release reschedule and the start of a dispatch fall on neighbouring cycles. Overflow is reached by walking the counter up to its ceiling and back down.

// File: rtl/iwd_pkg.sv
package iwd_pkg;

    typedef enum logic [1:0] {
        ACT_WAKE   = 2'd0,
        ACT_SETBIT = 2'd1,
        ACT_SCAN   = 2'd2
    } act_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PICK  = 2'd1,
        ST_ISSUE = 2'd2
    } seq_state_e;

    typedef struct packed {
        act_kind_e  kind;
        logic [3:0] level;
    } action_t;

endpackage

// File: rtl/iwd_disable_ctr.sv
module iwd_disable_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             err,
    output logic             is_zero,
    output logic             release_hit
);
    localparam logic [CNT_W-1:0] CNT_CEIL = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic up_only, dn_only, bad_up, bad_dn;

    always_comb begin
        up_only     = inc && !dec;
        dn_only     = dec && !inc;
        bad_up      = up_only && (count == CNT_CEIL);
        bad_dn      = dn_only && (count == '0);
        release_hit = dn_only && (count == CNT_ONE);
        is_zero     = (count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            if (up_only && !bad_up)
                count <= count + CNT_ONE;
            else if (dn_only && !bad_dn)
                count <= count - CNT_ONE;
            if (bad_up || bad_dn)
                err <= 1'b1;
            else if (clr)
                err <= 1'b0;
        end
    end

    a_r2_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
        (!inc && !dec) |=> $stable(count));
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err && !clr) |=> err);
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && count == '0) |=> (count == '0 && err));

endmodule

// File: rtl/iwd_pending.sv
module iwd_pending #(
    parameter int LEVELS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] req,
    input  logic [LEVELS-1:0] take,
    output logic [LEVELS-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else
            mask <= (mask & ~take) | req;
    end

    a_r4_new_req_kept: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |=> ((mask & $past(req)) == $past(req)));

endmodule

// File: rtl/iwd_sequencer.sv
module iwd_sequencer
    import iwd_pkg::*;
#(
    parameter int LEVELS = 16,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_zero,
    input  logic              release_hit,
    input  logic [LEVELS-1:0] pend,
    input  logic              idle_in,
    input  logic [LEVELS-1:0] q_empty,
    input  logic              ready,
    output logic [LEVELS-1:0] take,
    output logic              valid,
    output act_kind_e         kind,
    output logic [LVL_W-1:0]  level,
    output logic              resched
);
    localparam int TIMER_LVL = LEVELS - 1;

    seq_state_e        state;
    logic [LEVELS-1:0] snap;
    logic              woke;
    logic              idle_at_start;
    logic              start;
    logic [LVL_W-1:0]  next_lvl;
    logic              finishing;

    function automatic logic [LVL_W-1:0] highest_set(input logic [LEVELS-1:0] v);
        highest_set = '0;
        for (int i = 0; i < LEVELS; i++)
            if (v[i]) highest_set = LVL_W'(i);
    endfunction

    always_comb begin
        start     = (state == ST_IDLE) && cnt_zero && (pend != '0);
        take      = start ? pend : '0;
        next_lvl  = highest_set(snap);
        finishing = (state == ST_PICK) && (snap == '0);
        valid     = (state == ST_ISSUE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            snap          <= '0;
            woke          <= 1'b0;
            idle_at_start <= 1'b0;
            kind          <= ACT_WAKE;
            level         <= '0;
            resched       <= 1'b0;
        end else begin
            resched <= (finishing && (woke || idle_at_start))
                     || (release_hit && (pend != '0));
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        snap          <= pend;
                        woke          <= 1'b0;
                        idle_at_start <= idle_in;
                        state         <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (snap == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        level <= next_lvl;
                        if (snap[TIMER_LVL])
                            kind <= ACT_SCAN;
                        else if (q_empty[next_lvl])
                            kind <= ACT_SETBIT;
                        else
                            kind <= ACT_WAKE;
                        snap[next_lvl] <= 1'b0;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (ready) begin
                        if (kind == ACT_WAKE) woke <= 1'b1;
                        state <= ST_PICK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r6_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(level) && $stable(kind)));
    a_r5_scan_is_timer: assert property (@(posedge clk) disable iff (rst)
        (valid && kind == ACT_SCAN) |-> (level == LVL_W'(TIMER_LVL)));
    a_r5_timer_not_notified: assert property (@(posedge clk) disable iff (rst)
        (valid && kind != ACT_SCAN) |-> (level != LVL_W'(TIMER_LVL)));
    a_r4_gated_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !cnt_zero) |=> (state != ST_PICK));

endmodule

// File: rtl/irq_wake_dispatch.sv
module irq_wake_dispatch
    import iwd_pkg::*;
#(
    parameter int LEVELS = 16,
    parameter int CNT_W  = 8,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] irq_req,
    input  logic              dis_inc,
    input  logic              dis_dec,
    input  logic              err_clr,
    input  logic              cpu_idle,
    input  logic [LEVELS-1:0] q_empty,
    input  logic              act_ready,
    output logic              act_valid,
    output logic [1:0]        act_kind,
    output logic [LVL_W-1:0]  act_level,
    output logic              resched_req,
    output logic              wake_err,
    output logic [CNT_W-1:0]  dis_count
);
    logic              cnt_zero, release_hit;
    logic [LEVELS-1:0] pend, take;
    act_kind_e         kind;

    iwd_disable_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst(rst), .inc(dis_inc), .dec(dis_dec), .clr(err_clr),
        .count(dis_count), .err(wake_err), .is_zero(cnt_zero),
        .release_hit(release_hit)
    );

    iwd_pending #(.LEVELS(LEVELS)) u_pend (
        .clk(clk), .rst(rst), .req(irq_req), .take(take), .mask(pend)
    );

    iwd_sequencer #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_seq (
        .clk(clk), .rst(rst), .cnt_zero(cnt_zero), .release_hit(release_hit),
        .pend(pend), .idle_in(cpu_idle), .q_empty(q_empty), .ready(act_ready),
        .take(take), .valid(act_valid), .kind(kind), .level(act_level),
        .resched(resched_req)
    );

    assign act_kind = kind;

    a_r8_pulse_idle_gap: assert property (@(posedge clk) disable iff (rst)
        (act_valid && act_ready) |=> !resched_req || !act_valid);

endmodule

// File: tb/irq_wake_dispatch_test.sv
module irq_wake_dispatch_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] irq_req, q_empty;
    logic        dis_inc, dis_dec, err_clr, cpu_idle, act_ready;
    logic        act_valid, resched_req, wake_err;
    logic [1:0]  act_kind;
    logic [3:0]  act_level;
    logic [7:0]  dis_count;

    int tests = 0, fails = 0, cycles = 0;
    bit stall_mode = 0;
    bit checking = 0;

    irq_wake_dispatch uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .dis_inc(dis_inc),
        .dis_dec(dis_dec), .err_clr(err_clr), .cpu_idle(cpu_idle),
        .q_empty(q_empty), .act_ready(act_ready), .act_valid(act_valid),
        .act_kind(act_kind), .act_level(act_level), .resched_req(resched_req),
        .wake_err(wake_err), .dis_count(dis_count)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    int m_cnt, m_pend, m_snap, m_phase, m_kind, m_lvl;
    bit m_err, m_woke, m_idl, m_res;

    always @(posedge clk) begin
        int n_cnt, n_pend, n_snap, n_phase, n_kind, n_lvl;
        bit n_err, n_woke, n_idl, n_res, hit, bad, start;
        if (rst) begin
            m_cnt = 0; m_pend = 0; m_snap = 0; m_phase = 0; m_kind = 0;
            m_lvl = 0; m_err = 0; m_woke = 0; m_idl = 0; m_res = 0;
        end else begin
            n_cnt = m_cnt; n_err = m_err; hit = 0; bad = 0;
            if (dis_inc && !dis_dec) begin
                if (m_cnt == 127) bad = 1; else n_cnt = m_cnt + 1;
            end
            if (dis_dec && !dis_inc) begin
                if (m_cnt == 0) bad = 1;
                else begin hit = (m_cnt == 1); n_cnt = m_cnt - 1; end
            end
            if (bad) n_err = 1; else if (err_clr) n_err = 0;
            start = (m_phase == 0) && (m_cnt == 0) && (m_pend != 0);
            n_res = hit && (m_pend != 0);
            n_snap = m_snap; n_phase = m_phase; n_kind = m_kind; n_lvl = m_lvl;
            n_woke = m_woke; n_idl = m_idl;
            if (m_phase == 0) begin
                if (start) begin
                    n_snap = m_pend; n_woke = 0; n_idl = cpu_idle; n_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (m_snap == 0) begin
                    if (m_woke || m_idl) n_res = 1;
                    n_phase = 0;
                end else begin
                    for (int i = 15; i >= 0; i--)
                        if (m_snap[i]) begin n_lvl = i; break; end
                    if (n_lvl == 15) n_kind = 2;
                    else n_kind = q_empty[n_lvl] ? 1 : 0;
                    n_snap = m_snap & ~(1 << n_lvl);
                    n_phase = 2;
                end
            end else begin
                if (act_ready) begin
                    if (m_kind == 0) n_woke = 1;
                    n_phase = 1;
                end
            end
            n_pend = (start ? 0 : m_pend) | int'(irq_req);
            m_cnt = n_cnt; m_err = n_err; m_pend = n_pend; m_snap = n_snap;
            m_phase = n_phase; m_kind = n_kind; m_lvl = n_lvl; m_woke = n_woke;
            m_idl = n_idl; m_res = n_res;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (checking) begin
            check(dis_count == 8'(m_cnt), "R2 counter", dis_count, m_cnt);
            check(wake_err == m_err, "R3 error flag", wake_err, m_err);
            check(act_valid == (m_phase == 2), "R4 action valid", act_valid, m_phase == 2);
            if (m_phase == 2) begin
                check(act_level == 4'(m_lvl), "R6 level order", act_level, m_lvl);
                check(act_kind == 2'(m_kind), "R7 kind (R5 scan)", act_kind, m_kind);
            end
            check(resched_req == m_res, "R8/R9 reschedule", resched_req, m_res);
        end
        act_ready <= stall_mode ? (cycles % 3 == 0) : 1'b1;
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
        irq_req = '0; dis_inc = 0; dis_dec = 0; err_clr = 0;
    endtask

    task automatic irq(input logic [15:0] m);
        @(negedge clk); irq_req = m; step();
    endtask

    task automatic settle();
        for (int k = 0; k < 200; k++) begin
            if (m_phase == 0 && m_pend == 0) break;
            step();
        end
        step(3);
    endtask

    initial begin
        rst = 1; irq_req = '0; q_empty = '0; dis_inc = 0; dis_dec = 0;
        err_clr = 0; cpu_idle = 0; act_ready = 1;
        step(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(dis_count == 0, "R1 count after reset", dis_count, 0);
        check(!act_valid, "R1 valid after reset", act_valid, 0);
        check(!wake_err, "R1 err after reset", wake_err, 0);
        check(!resched_req, "R1 resched after reset", resched_req, 0);
        checking = 1;

        // R7 mixed wake / set-waiting, R6 order
        q_empty = 16'h0009;
        irq(16'h0089); settle();

        // R5 timer plus others, stalled handshake
        stall_mode = 1; q_empty = 16'h0004;
        irq(16'h8204); settle();

        // R8 idle-start with only set-waiting actions
        stall_mode = 0; q_empty = 16'hFFFF; cpu_idle = 1;
        irq(16'h0012); settle();
        cpu_idle = 0;
        irq(16'h0012); settle();

        // R4 counter held: requests wait; R9 release while pending
        @(negedge clk); dis_inc = 1; step();
        @(negedge clk); dis_inc = 1; step();
        q_empty = 16'h0000;
        irq(16'h0041); step(4);
        @(negedge clk); dis_dec = 1; step();
        @(negedge clk); dis_dec = 1; step();
        settle();

        // R4 requests arriving during a stalled dispatch
        stall_mode = 1; q_empty = 16'h00F0;
        irq(16'h0300);
        step(2); irq(16'h0030); irq(16'h8000);
        settle(); stall_mode = 0;

        // R2 simultaneous inc and dec
        @(negedge clk); dis_inc = 1; dis_dec = 1; step();
        // R3 underflow and clear
        @(negedge clk); dis_dec = 1; step(2);
        @(negedge clk); err_clr = 1; step(2);
        // R3 overflow at ceiling
        for (int k = 0; k < 128; k++) begin @(negedge clk); dis_inc = 1; step(); end
        check(dis_count == 127, "R3 count at ceiling", dis_count, 127);
        check(wake_err, "R3 overflow sets error", wake_err, 1);
        @(negedge clk); err_clr = 1; step();
        for (int k = 0; k < 127; k++) begin @(negedge clk); dis_dec = 1; step(); end
        check(dis_count == 0, "R2 count back to zero", dis_count, 0);
        irq(16'h0001); settle();

        checking = 0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        fails++; tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule